// File: doc/BRIEF.md
# Bubble-Tolerant Flash Thermometer Encoder

This block turns the raw decision vector of a flash converter's comparator bank into an N-bit output code. A bank for N bits holds 2^N−1 comparators. Comparator j (numbered 1 to 2^N−1, carried on input bit j−1) reads 1 when the analog input lies above its reference level. A clean sample is therefore a run of ones from bit 0 upward, followed by zeros. The block does not search for the highest set comparator. Each output bit is a parity (XOR) over a fixed subset of comparators, and the result is a Gray code. A comparator that fires by mistake above the true level then flips only one Gray bit. With a highest-one search, the same fault would send the output close to the stray comparator's own position.

The Gray code is converted to binary in the same cycle. Both codes are registered and leave the block together with a valid flag. A sample is captured only when its valid input is high. The output registers keep their last code until the next valid sample reaches them. The block is parameterised by N and is meant to be used at N=3 and N=8.

The Gray subset rule: Gray bit k is the parity of every comparator j whose lowest set bit is bit k, so that j is an odd multiple of 2^k. For N=3 this gives g2=t4, g1=t2^t6 and g0=t1^t3^t5^t7. Binary bit N−1 equals Gray bit N−1, and each lower binary bit is the binary bit above it XOR its own Gray bit.

Top module: `thermo_gray_enc`

## Requirements
- R1: A clean thermometer sample with L ones (bits 0..L−1 set) produces bin_o = L and gray_o = L ^ (L >> 1).
- R2: At N=3 the sample 7'b0001111 produces bin_o = 3'b100.
- R3: A sample with L clean ones and one extra set comparator at position p ≥ L+2 yields L with its low tz(p)+1 bits inverted, where tz(p) is the number of trailing zeros of p. The error is therefore at most 2^(tz(p)+1)−1, and it is exactly one LSB when p is odd.
- R4: An all-zero sample decodes to 0, and an all-ones sample decodes to 2^N−1.
- R5: Whenever code_vld_o is high, gray_o equals bin_o ^ (bin_o >> 1).
- R6: The result of a sample accepted at clock edge E appears after edge E+1. code_vld_o is high exactly two edges after sample_vld_i was high.
- R7: While sample_vld_i is low, the comparator input is ignored and gray_o and bin_o keep their last values.
- R8: While rst_n is low, and after its release until the first valid result, gray_o, bin_o and code_vld_o are all zero.
- R9: The same rules hold with N=3, with seven comparator inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_i | input | 2^N−1 | Comparator decisions; bit j−1 carries comparator j |
| sample_vld_i | input | 1 | Qualifies therm_i for capture |
| gray_o | output | N | Registered Gray code |
| bin_o | output | N | Registered binary code |
| code_vld_o | output | 1 | High for one cycle per decoded sample |

## Verification
The bench sweeps every clean level at both widths, including the empty and full extremes. A design with a misrouted XOR tap, or with an off-by-one comparator index, gives a wrong value at some level. It then places a single stray comparator at every position above every level. The expected value comes from an independent parity model, and the error is held to a bound that depends on the trailing zeros of the stray comparator's position. A highest-one search would report the stray comparator's position and break that bound. Between bursts, idle cycles with toggling garbage on the comparator input catch a capture stage that ignores the valid input, and scoreboard ordering catches any latency other than two cycles.

// File: rtl/thg_pkg.sv
package thg_pkg;

    // number of comparators feeding an n-bit conversion
    function automatic int unsigned comp_count(input int unsigned n);
        return (32'd1 << n) - 32'd1;
    endfunction

endpackage

// File: rtl/thg_capture.sv
module thg_capture #(
    parameter int unsigned TW = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] therm_i,
    input  logic          vld_i,
    output logic [TW-1:0] therm_q,
    output logic          vld_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            therm_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= vld_i;
            if (vld_i) begin
                therm_q <= therm_i;
            end
        end
    end

endmodule

// File: rtl/thg_gray_net.sv
module thg_gray_net #(
    parameter int unsigned N = 8
) (
    input  logic [thg_pkg::comp_count(N)-1:0] therm_i,
    output logic [N-1:0]                      gray_o
);

    localparam int unsigned TW = thg_pkg::comp_count(N);

    // Gray bit k gathers comparators whose index is an odd multiple of 2^k
    for (genvar k = 0; k < N; k++) begin : g_bit
        logic [TW-1:0] tap;
        for (genvar j = 1; j <= TW; j++) begin : g_tap
            if ((((j >> k) & 1) == 1) && ((j & ((1 << k) - 1)) == 0)) begin : g_on
                assign tap[j-1] = therm_i[j-1];
            end else begin : g_off
                assign tap[j-1] = 1'b0;
            end
        end
        assign gray_o[k] = ^tap;
    end

endmodule

// File: rtl/thg_gray_to_bin.sv
module thg_gray_to_bin #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] gray_i,
    output logic [N-1:0] bin_o
);

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int k = int'(N) - 1; k >= 0; k--) begin
            acc      = acc ^ gray_i[k];
            bin_o[k] = acc;
        end
    end

endmodule

// File: rtl/thg_hold.sv
module thg_hold #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [N-1:0] gray_i,
    input  logic [N-1:0] bin_i,
    output logic [N-1:0] gray_o,
    output logic [N-1:0] bin_o,
    output logic         vld_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gray_o <= '0;
            bin_o  <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                gray_o <= gray_i;
                bin_o  <= bin_i;
            end
        end
    end

endmodule

// File: rtl/thermo_gray_enc.sv
module thermo_gray_enc #(
    parameter int unsigned N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(2**N)-2:0]     therm_i,
    input  logic                  sample_vld_i,
    output logic [N-1:0]          gray_o,
    output logic [N-1:0]          bin_o,
    output logic                  code_vld_o
);

    localparam int unsigned TW = thg_pkg::comp_count(N);

    logic [TW-1:0] cap_therm;
    logic          cap_vld;
    logic [N-1:0]  net_gray;
    logic [N-1:0]  net_bin;

    thg_capture #(.TW(TW)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .therm_i (therm_i),
        .vld_i   (sample_vld_i),
        .therm_q (cap_therm),
        .vld_q   (cap_vld)
    );

    thg_gray_net #(.N(N)) u_gray_net (
        .therm_i (cap_therm),
        .gray_o  (net_gray)
    );

    thg_gray_to_bin #(.N(N)) u_g2b (
        .gray_i (net_gray),
        .bin_o  (net_bin)
    );

    thg_hold #(.N(N)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (cap_vld),
        .gray_i (net_gray),
        .bin_i  (net_bin),
        .gray_o (gray_o),
        .bin_o  (bin_o),
        .vld_o  (code_vld_o)
    );

endmodule

// File: rtl/thermo_gray_enc_chk.sv
module thermo_gray_enc_chk #(
    parameter int unsigned N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [(2**N)-2:0] therm_i,
    input logic              sample_vld_i,
    input logic [N-1:0]      gray_o,
    input logic [N-1:0]      bin_o,
    input logic              code_vld_o
);

    localparam int unsigned TW = thg_pkg::comp_count(N);

    logic [1:0]   age;
    logic         in_clean;
    logic [N-1:0] in_ones;

    assign in_clean = ((therm_i & (therm_i + TW'(1))) == '0);
    assign in_ones  = N'($countones(therm_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    // R6: valid flag trails the sample qualifier by two edges
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (code_vld_o == $past(sample_vld_i, 2)));

    // R1: clean samples decode to their count of ones
    a_r1_clean_level: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(sample_vld_i, 2) && $past(in_clean, 2))
        |-> (bin_o == $past(in_ones, 2)));

    // R5: both output codes describe the same value
    a_r5_gray_matches_bin: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |-> (gray_o == (bin_o ^ (bin_o >> 1))));

    // R7: no capture, no change
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && !$past(sample_vld_i, 2)) |-> ($stable(gray_o) && $stable(bin_o)));

    // R8: outputs cleared while reset is held
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (code_vld_o == 1'b0 && bin_o == '0 && gray_o == '0));

endmodule

bind thermo_gray_enc thermo_gray_enc_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .therm_i      (therm_i),
    .sample_vld_i (sample_vld_i),
    .gray_o       (gray_o),
    .bin_o        (bin_o),
    .code_vld_o   (code_vld_o)
);

// File: tb/thermo_gray_enc_test.sv
`timescale 1ns/1ps
module thermo_gray_enc_test;

    typedef struct {
        int    exp_bin;
        int    lvl;
        int    bub;
        string req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [254:0] therm8 = '0;
    logic         vld8 = 1'b0;
    logic [6:0]   therm3 = '0;
    logic         vld3 = 1'b0;
    logic [7:0]   gray8, bin8;
    logic [2:0]   gray3, bin3;
    logic         cv8, cv3;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    item_t q8[$];
    item_t q3[$];

    always #2.5 clk = ~clk;

    thermo_gray_enc #(.N(8)) uut (
        .clk(clk), .rst_n(rst_n), .therm_i(therm8), .sample_vld_i(vld8),
        .gray_o(gray8), .bin_o(bin8), .code_vld_o(cv8));

    thermo_gray_enc #(.N(3)) uut_n3 (
        .clk(clk), .rst_n(rst_n), .therm_i(therm3), .sample_vld_i(vld3),
        .gray_o(gray3), .bin_o(bin3), .code_vld_o(cv3));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tz(input int v);
        int c = 0;
        while (((v >> c) & 1) == 0 && c < 31) c++;
        return c;
    endfunction

    // independent parity model of the encoder
    function automatic int ref_decode(input logic [254:0] t, input int n);
        int g = 0;
        int b = 0;
        int acc = 0;
        for (int j = 1; j < (1 << n); j++)
            if (t[j-1]) g = g ^ (1 << tz(j));
        for (int k = n - 1; k >= 0; k--) begin
            acc = acc ^ ((g >> k) & 1);
            b   = b | (acc << k);
        end
        return b;
    endfunction

    function automatic logic [254:0] therm_of(input int lvl);
        logic [254:0] v = '0;
        for (int j = 0; j < lvl; j++) v[j] = 1'b1;
        return v;
    endfunction

    task automatic send8(input logic [254:0] t, input int e, input int l, input int b, input string r);
        @(negedge clk);
        therm8 = t; vld8 = 1'b1; vld3 = 1'b0;
        q8.push_back('{exp_bin: e, lvl: l, bub: b, req: r});
    endtask

    task automatic send3(input logic [6:0] t, input int e, input int l, input int b, input string r);
        @(negedge clk);
        therm3 = t; vld3 = 1'b1; vld8 = 1'b0;
        q3.push_back('{exp_bin: e, lvl: l, bub: b, req: r});
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            vld8 = 1'b0; vld3 = 1'b0;
            therm8 = ~therm8 ^ {85{3'b101}};
            therm3 = ~therm3 ^ 7'b0110101;
        end
    endtask

    task automatic judge(input int act, input item_t it, input int gact);
        int d;
        int m;
        check(act == it.exp_bin, it.req, act, it.exp_bin);
        check(gact == (it.exp_bin ^ (it.exp_bin >> 1)), "R5", gact, it.exp_bin ^ (it.exp_bin >> 1));
        if (it.bub > 0) begin
            d = (act > it.lvl) ? act - it.lvl : it.lvl - act;
            m = (2 << tz(it.bub)) - 1;
            check(d <= m, "R3 bound", d, m);
            if ((it.bub % 2) == 1) check(d == 1, "R3 odd stray", d, 1);
        end
    endtask

    // monitor for the 8-bit instance
    bit seen8 = 1'b0;
    int last_g8 = 0, last_b8 = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cv8) begin
                if (q8.size() == 0) check(1'b0, "R6 unexpected", int'(bin8), -1);
                else judge(int'(bin8), q8.pop_front(), int'(gray8));
                last_g8 = int'(gray8); last_b8 = int'(bin8); seen8 = 1'b1;
            end else if (seen8) begin
                check(int'(gray8) == last_g8 && int'(bin8) == last_b8, "R7", int'(bin8), last_b8);
            end else begin
                check(bin8 == 8'd0 && gray8 == 8'd0, "R8", int'(bin8), 0);
            end
        end
    end

    // monitor for the 3-bit instance
    bit seen3 = 1'b0;
    int last_g3 = 0, last_b3 = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cv3) begin
                if (q3.size() == 0) check(1'b0, "R6 unexpected", int'(bin3), -1);
                else judge(int'(bin3), q3.pop_front(), int'(gray3));
                last_g3 = int'(gray3); last_b3 = int'(bin3); seen3 = 1'b1;
            end else if (seen3) begin
                check(int'(gray3) == last_g3 && int'(bin3) == last_b3, "R7", int'(bin3), last_b3);
            end else begin
                check(bin3 == 3'd0 && gray3 == 3'd0, "R8", int'(bin3), 0);
            end
        end
    end

    initial begin
        logic [254:0] t;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cv8 == 1'b0 && bin8 == 8'd0 && gray8 == 8'd0, "R8", int'(bin8), 0);
        check(cv3 == 1'b0 && bin3 == 3'd0, "R8", int'(bin3), 0);
        rst_n = 1'b1;
        idle(3);

        // R9: narrow instance, clean sweep then strays
        for (int l = 0; l <= 7; l++)
            send3(therm_of(l)[6:0], l, l, 0, (l == 4) ? "R2" : ((l == 0 || l == 7) ? "R4" : "R9"));
        idle(4);
        for (int l = 0; l <= 5; l++)
            for (int p = l + 2; p <= 7; p++) begin
                t = therm_of(l); t[p-1] = 1'b1;
                send3(t[6:0], ref_decode(t, 3), l, p, "R3 R9");
            end
        idle(4);

        // wide instance: clean sweep, R1 / R4
        for (int l = 0; l <= 255; l++) begin
            send8(therm_of(l), l, l, 0, (l == 0 || l == 255) ? "R4" : "R1");
            if ((l % 37) == 36) idle(2);
        end
        idle(4);
        for (int l = 0; l <= 253; l++)
            for (int p = l + 2; p <= 255; p++) begin
                t = therm_of(l); t[p-1] = 1'b1;
                send8(t, ref_decode(t, 8), l, p, "R3");
            end
        idle(6);
        check(q8.size() == 0, "R6 pending", q8.size(), 0);
        check(q3.size() == 0, "R6 pending", q3.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule